// File: doc/BRIEF.md
# Cascaded Programmable Sync-Wave Counter

This block is a small bank of identical timing counters that are chained together to build a display timing chain. Examples are a line sync, a frame sync, a line-active window and a pixel-active window. Each counter has a programmable period, a start delay, a repeat count and an output waveform. The waveform has rising and falling edges placed in half-pixel steps. The counters are generic. What each one becomes depends on which event advances it and which event restarts it.

Three selectable sources drive each counter:

- a trigger that advances its period position;
- a trigger that advances its start delay;
- a clear event that restarts it.

A source is either the pixel clock enable or the terminal pulse of another counter. A pulse from a lower-numbered counter is seen by higher-numbered counters in the same cycle, so a whole chain settles within one pixel slot. A source that names the counter itself or a higher-numbered counter sees that pulse one pixel slot late.

All state advances only on cycles where the pixel clock enable is high. Dropping the global enable returns every counter to its idle state.

Top module: `syncwave_chain`

## Requirements
- R1: While `enable` is low, and after reset, no counter pulses. Every counter is idle, so each pin pair equals that counter's invert bit on both halves.
- R2: A running counter whose period-advance trigger fires has two outcomes. If its position equals the programmed period-minus-one (timing word bits 11:0), it emits a pulse for exactly that enabled cycle and its position returns to 0. Otherwise its position increments. So the pulses are spaced period-minus-one plus one triggers apart.
- R3: After a (re)start, the counter waits for the number of delay-trigger events given by the offset field (timing word bits 27:16) before it starts counting periods. A pulse-per-clock counter with offset d and period-minus-one p therefore first pulses d+p enabled cycles after the start cycle. An offset of 0 means no wait.
- R4: A repeat field (repeat word bits 11:0) of 0 makes the counter run forever. A nonzero value n stops it after n pulses until its clear source fires again.
- R5: Source codes are 3 bits: 0 is never, 1 is the pixel clock enable, and k+1 is the pulse of counter k (counter 1 is index 0). Period source is timing word bits 14:12; delay source is timing word bits 30:28; clear source is shape word bits 22:20.
- R6: When a counter's clear source fires, the counter reloads its delay, its repeat count and a position of 0. A counter whose clear source is 0 starts itself on the first enabled cycle; any other counter stays stopped until its first clear.
- R7: A clear that arrives together with a period trigger wins: no pulse is emitted, and the counter restarts.
- R8: While running, the waveform (enabled by shape word bit 23) is high in every half slot h with up ≤ h < down. Up is shape word bits 9:0 and down is bits 19:10. Position c covers half slots 2c (`pin_early`) and 2c+1 (`pin_late`). The waveform is low when the counter is not running.
- R9: Shape word bit 24 inverts both halves of that counter's pin.
- R10: A cycle with `pix_ce` low advances no counter and emits no pulse.
- R11: A write sets one word of one counter: `cfg_word` 0 is the timing word, 1 is the shape word, 2 is the repeat word, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| enable | input | 1 | Global run enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctr | input | IDX_W | Counter index of the write |
| cfg_word | input | 2 | Word select of the write |
| cfg_wdata | input | 32 | Write data |
| ctr_pulse | output | N_CTR | Terminal pulse per counter |
| pin_early | output | N_CTR | Pin level in the first half of the pixel slot |
| pin_late | output | N_CTR | Pin level in the second half of the pixel slot |

## Verification
The stability property assumes two things. First, configuration writes happen only while the chain is disabled. Second, `pix_ce` is synchronous to `clk`. The bench keeps to both: it programs every counter with `enable` low and only then raises it. The pulse and clear properties assume each counter's sources are used as wired, with no other agent resetting state mid-run. The bench's cascade run programs sources only with lower-numbered counters, so every observed pulse belongs to the same pixel slot that caused it.

// File: rtl/syncwave_pkg.sv
package syncwave_pkg;
  localparam int CNT_W = 12;
  localparam int POS_W = 10;
  localparam int SRC_W = 3;

  localparam logic [1:0] WORD_TIMING = 2'd0;
  localparam logic [1:0] WORD_SHAPE  = 2'd1;
  localparam logic [1:0] WORD_REPEAT = 2'd2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RUN   = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] run_m1;
    logic [SRC_W-1:0] run_src;
    logic [CNT_W-1:0] offset;
    logic [SRC_W-1:0] off_src;
    logic [POS_W-1:0] up_pos;
    logic [POS_W-1:0] down_pos;
    logic [SRC_W-1:0] clr_src;
    logic             wave_en;
    logic             invert;
    logic [CNT_W-1:0] rep_n;
  } ctr_cfg_t;
endpackage

// File: rtl/syncwave_cfg.sv
module syncwave_cfg
  import syncwave_pkg::*;
#(
  parameter int N_CTR = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] ctr,
  input  logic [1:0]       word,
  input  logic [31:0]      wdata,
  output ctr_cfg_t         cfg_o [N_CTR]
);
  for (genvar i = 0; i < N_CTR; i++) begin : g_entry
    ctr_cfg_t q, d;

    always_comb begin
      d = q;
      if (we && (ctr == IDX_W'(i))) begin
        unique case (word)
          WORD_TIMING: begin
            d.run_m1  = wdata[CNT_W-1:0];
            d.run_src = wdata[12 +: SRC_W];
            d.offset  = wdata[16 +: CNT_W];
            d.off_src = wdata[28 +: SRC_W];
          end
          WORD_SHAPE: begin
            d.up_pos   = wdata[POS_W-1:0];
            d.down_pos = wdata[10 +: POS_W];
            d.clr_src  = wdata[20 +: SRC_W];
            d.wave_en  = wdata[23];
            d.invert   = wdata[24];
          end
          WORD_REPEAT: d.rep_n = wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign cfg_o[i] = q;
  end
endmodule

// File: rtl/syncwave_srcsel.sv
module syncwave_srcsel
  import syncwave_pkg::*;
#(
  parameter int N_CTR = 6
) (
  input  logic [SRC_W-1:0] code,
  input  logic             pix_ce,
  input  logic [N_CTR-1:0] avail,
  output logic             hit
);
  localparam int N_CODES = 1 << SRC_W;

  always_comb begin
    hit = 1'b0;
    if (code == SRC_W'(1)) begin
      hit = pix_ce;
    end else begin
      for (int j = 0; j < N_CTR; j++) begin
        if ((j + 2 < N_CODES) && (int'(code) == j + 2)) hit = avail[j];
      end
    end
  end
endmodule

// File: rtl/syncwave_unit.sv
module syncwave_unit
  import syncwave_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pix_ce,
  input  logic [CNT_W-1:0] run_m1,
  input  logic [CNT_W-1:0] offset,
  input  logic [CNT_W-1:0] rep_n,
  input  logic [POS_W-1:0] up_pos,
  input  logic [POS_W-1:0] down_pos,
  input  logic             wave_en,
  input  logic             invert,
  input  logic             self_start,
  input  logic             run_hit,
  input  logic             off_hit,
  input  logic             clr_hit,
  output logic             pulse,
  output logic             pin_e,
  output logic             pin_l,
  output logic [CNT_W-1:0] pos
);
  localparam int HS_W = CNT_W + 1;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] rep_q, rep_d;
  logic             step;

  assign step = enable && pix_ce;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    off_d = off_q;
    rep_d = rep_q;
    pulse = 1'b0;
    if (!enable) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (step) begin
      if (clr_hit || (ph_q == PH_IDLE && self_start)) begin
        cnt_d = '0;
        off_d = offset;
        rep_d = rep_n;
        ph_d  = (offset == '0) ? PH_RUN : PH_DELAY;
      end else begin
        unique case (ph_q)
          PH_IDLE: ph_d = PH_STOP;
          PH_DELAY: begin
            if (off_hit) begin
              if (off_q <= CNT_W'(1)) begin
                ph_d  = PH_RUN;
                cnt_d = '0;
              end else begin
                off_d = off_q - CNT_W'(1);
              end
            end
          end
          PH_RUN: begin
            if (run_hit) begin
              if (cnt_q >= run_m1) begin
                pulse = 1'b1;
                cnt_d = '0;
                if (rep_q != '0) begin
                  rep_d = rep_q - CNT_W'(1);
                  if (rep_q == CNT_W'(1)) ph_d = PH_STOP;
                end
              end else begin
                cnt_d = cnt_q + CNT_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      off_q <= '0;
      rep_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      off_q <= off_d;
      rep_q <= rep_d;
    end
  end

  logic [HS_W-1:0] hs_e, hs_l, up_x, dn_x;
  logic            live;

  assign hs_e  = {cnt_q, 1'b0};
  assign hs_l  = {cnt_q, 1'b1};
  assign up_x  = {{(HS_W-POS_W){1'b0}}, up_pos};
  assign dn_x  = {{(HS_W-POS_W){1'b0}}, down_pos};
  assign live  = wave_en && (ph_q == PH_RUN);
  assign pin_e = (live && hs_e >= up_x && hs_e < dn_x) ^ invert;
  assign pin_l = (live && hs_l >= up_x && hs_l < dn_x) ^ invert;
  assign pos   = cnt_q;
endmodule

// File: rtl/syncwave_chain.sv
module syncwave_chain
  import syncwave_pkg::*;
#(
  parameter int N_CTR = 6,
  parameter int IDX_W = $clog2(N_CTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_ce,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_ctr,
  input  logic [1:0]       cfg_word,
  input  logic [31:0]      cfg_wdata,
  output logic [N_CTR-1:0] ctr_pulse,
  output logic [N_CTR-1:0] pin_early,
  output logic [N_CTR-1:0] pin_late
);
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  ctr_cfg_t         cfg [N_CTR];
  logic [N_CTR-1:0] held_q, held_d;
  logic [N_CTR-1:0] clr_hit;
  logic [CNT_W-1:0] ctr_pos [N_CTR];

  syncwave_cfg #(.N_CTR(N_CTR), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .we(cfg_we), .ctr(cfg_ctr),
    .word(cfg_word), .wdata(cfg_wdata), .cfg_o(cfg)
  );

  always_comb begin
    held_d = held_q;
    if (!enable)     held_d = '0;
    else if (pix_ce) held_d = ctr_pulse;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) held_q <= '0;
    else             held_q <= held_d;
  end

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    logic [N_CTR-1:0] avail;
    logic             run_hit, off_hit;

    always_comb begin
      for (int j = 0; j < N_CTR; j++) avail[j] = (j < i) ? ctr_pulse[j] : held_q[j];
    end

    syncwave_srcsel #(.N_CTR(N_CTR)) u_run (
      .code(cfg[i].run_src), .pix_ce(pix_ce), .avail(avail), .hit(run_hit));
    syncwave_srcsel #(.N_CTR(N_CTR)) u_off (
      .code(cfg[i].off_src), .pix_ce(pix_ce), .avail(avail), .hit(off_hit));
    syncwave_srcsel #(.N_CTR(N_CTR)) u_clr (
      .code(cfg[i].clr_src), .pix_ce(pix_ce), .avail(avail), .hit(clr_hit[i]));

    syncwave_unit u_unit (
      .clk(clk), .rst_n(rst_core_n), .enable(enable), .pix_ce(pix_ce),
      .run_m1(cfg[i].run_m1), .offset(cfg[i].offset), .rep_n(cfg[i].rep_n),
      .up_pos(cfg[i].up_pos), .down_pos(cfg[i].down_pos),
      .wave_en(cfg[i].wave_en), .invert(cfg[i].invert),
      .self_start(cfg[i].clr_src == '0),
      .run_hit(run_hit), .off_hit(off_hit), .clr_hit(clr_hit[i]),
      .pulse(ctr_pulse[i]), .pin_e(pin_early[i]), .pin_l(pin_late[i]),
      .pos(ctr_pos[i])
    );
  end
endmodule

// File: rtl/syncwave_chain_chk.sv
module syncwave_chain_chk
  import syncwave_pkg::*;
#(
  parameter int N_CTR = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_ce,
  input logic             enable,
  input logic             cfg_we,
  input logic [N_CTR-1:0] ctr_pulse,
  input logic [N_CTR-1:0] pin_early,
  input logic [N_CTR-1:0] pin_late,
  input logic [N_CTR-1:0] clr_hit,
  input logic [CNT_W-1:0] ctr_pos [N_CTR]
);
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cfg_we) |=> (pin_early == pin_late));

  assert_hold_without_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && !cfg_we && enable) |=> ($stable(pin_early) && $stable(pin_late)));

  for (genvar i = 0; i < N_CTR; i++) begin : g_chk
    assert_wrap_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_pulse[i] |=> (ctr_pos[i] == '0));

    assert_clear_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && pix_ce && enable) |=> (ctr_pos[i] == '0));

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[i] |-> !ctr_pulse[i]);
  end
endmodule

bind syncwave_chain syncwave_chain_chk #(.N_CTR(N_CTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .enable(enable), .cfg_we(cfg_we),
  .ctr_pulse(ctr_pulse), .pin_early(pin_early), .pin_late(pin_late),
  .clr_hit(clr_hit), .ctr_pos(ctr_pos)
);

// File: tb/syncwave_chain_test.sv
`timescale 1ns/1ps
module syncwave_chain_test;
  localparam int N = 6;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n, pix_ce, enable, cfg_we;
  logic [IW-1:0] cfg_ctr;
  logic [1:0]    cfg_word;
  logic [31:0]   cfg_wdata;
  logic [N-1:0]  ctr_pulse, pin_early, pin_late;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  syncwave_chain #(.N_CTR(N), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .enable(enable),
    .cfg_we(cfg_we), .cfg_ctr(cfg_ctr), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .ctr_pulse(ctr_pulse),
    .pin_early(pin_early), .pin_late(pin_late)
  );

  // {period-1, offset, repeat, expected first pulse cycle, expected pulses in 64 cycles}
  localparam int VEC [6][5] = '{
    '{0, 0, 0, 0, 64},
    '{3, 0, 0, 3, 16},
    '{4, 2, 0, 6, 12},
    '{2, 5, 4, 7, 4},
    '{9, 0, 3, 9, 3},
    '{7, 1, 0, 8, 7}
  };

  logic [N-1:0] rec_p [0:26];
  logic [N-1:0] rec_e [0:26];

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w_tim(int run, int rs, int off, int os);
    return 32'((run & 'hfff) | (rs << 12) | ((off & 'hfff) << 16) | (os << 28));
  endfunction
  function automatic logic [31:0] w_shp(int up, int dn, int clr, int we, int inv);
    return 32'((up & 'h3ff) | ((dn & 'h3ff) << 10) | (clr << 20) | (we << 23) | (inv << 24));
  endfunction

  task automatic wr(int c, int w, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctr = IW'(c); cfg_word = 2'(w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    enable = 1'b0; pix_ce = 1'b1; cfg_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_ce = 1'b1; enable = 1'b0; cfg_we = 1'b0;
    cfg_ctr = '0; cfg_word = '0; cfg_wdata = '0;

    // Reset state (R1) and invert while disabled (R9)
    do_reset();
    chk("R1", "pulses after reset", int'(ctr_pulse), 0);
    chk("R1", "early pins after reset", int'(pin_early), 0);
    chk("R1", "late pins after reset", int'(pin_late), 0);
    wr(5, 1, w_shp(0, 0, 0, 1, 1));
    chk("R9", "idle inverted pin", int'(pin_early[5]), 1);

    // Period / offset / repeat table (R2 R3 R4 R5)
    for (int v = 0; v < 6; v++) begin
      int first, cnt;
      do_reset();
      wr(0, 0, w_tim(VEC[v][0], 1, VEC[v][1], 1));
      wr(0, 2, 32'(VEC[v][2]));
      enable = 1'b1;
      first = -1; cnt = 0;
      for (int c = 0; c < 64; c++) begin
        @(posedge clk); #1;
        if (ctr_pulse[0]) begin
          if (first < 0) first = c;
          cnt++;
        end
      end
      chk("R3", $sformatf("vector %0d first pulse", v), first, VEC[v][3]);
      chk("R4", $sformatf("vector %0d pulse count (R2)", v), cnt, VEC[v][4]);
      @(negedge clk); enable = 1'b0;
    end

    // Half-slot pin levels (R8) and inversion (R9)
    do_reset();
    wr(0, 0, w_tim(3, 1, 0, 0));
    wr(0, 1, w_shp(2, 5, 0, 1, 0));
    wr(1, 0, w_tim(3, 1, 0, 0));
    wr(1, 1, w_shp(2, 5, 0, 1, 1));
    enable = 1'b1;
    for (int c = 0; c < 4; c++) begin
      int ee, el;
      ee = (c == 1 || c == 2) ? 1 : 0;
      el = (c == 1) ? 1 : 0;
      @(posedge clk); #1;
      chk("R8", $sformatf("early half pos %0d", c), int'(pin_early[0]), ee);
      chk("R8", $sformatf("late half pos %0d", c), int'(pin_late[0]), el);
      chk("R9", $sformatf("inverted early pos %0d", c), int'(pin_early[1]), 1 - ee);
    end
    @(negedge clk); enable = 1'b0;
    @(posedge clk); #1;
    chk("R1", "disabled pulses", int'(ctr_pulse), 0);
    chk("R1", "disabled inverted pin early", int'(pin_early[1]), 1);
    chk("R1", "disabled inverted pin late", int'(pin_late[1]), 1);
    chk("R1", "disabled plain pin", int'(pin_early[0]), 0);

    // Cascade, clear and clear priority (R5 R6 R7)
    do_reset();
    wr(0, 0, w_tim(3, 1, 0, 0));
    wr(1, 0, w_tim(2, 2, 0, 0));
    wr(2, 0, w_tim(0, 1, 1, 1));
    wr(2, 1, w_shp(0, 0, 3, 0, 0));
    wr(2, 2, 32'd2);
    wr(3, 0, w_tim(3, 1, 0, 0));
    wr(3, 1, w_shp(0, 2, 2, 1, 0));
    wr(2, 3, 32'hffff_ffff);  // ignored word select (R11)
    enable = 1'b1;
    for (int c = 0; c < 27; c++) begin
      @(posedge clk); #1;
      rec_p[c] = ctr_pulse;
      rec_e[c] = pin_early;
    end
    @(negedge clk); enable = 1'b0;
    chk("R5", "chained counter quiet at 7", int'(rec_p[7][1]), 0);
    chk("R5", "chained counter pulses at 11", int'(rec_p[11][1]), 1);
    chk("R5", "line counter pulses at 11", int'(rec_p[11][0]), 1);
    chk("R6", "cleared counter waits at 5", int'(rec_p[5][2]), 0);
    chk("R6", "delay after clear at 12", int'(rec_p[12][2]), 0);
    chk("R4", "first repeat at 13", int'(rec_p[13][2]), 1);
    chk("R4", "second repeat at 14", int'(rec_p[14][2]), 1);
    chk("R4", "stopped at 15 (R11)", int'(rec_p[15][2]), 0);
    chk("R6", "restart by next clear at 25", int'(rec_p[25][2]), 1);
    chk("R6", "not running before clear", int'(rec_e[2][3]), 0);
    chk("R6", "running from clear at 4", int'(rec_e[4][3]), 1);
    chk("R8", "position advanced at 5", int'(rec_e[5][3]), 0);
    chk("R7", "clear beats terminal pulse at 7", int'(rec_p[7][3]), 0);
    chk("R7", "reloaded to position 0 at 8", int'(rec_e[8][3]), 1);

    // Clock enable gating (R10)
    do_reset();
    wr(0, 0, w_tim(0, 1, 0, 0));
    pix_ce = 1'b0;
    enable = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      chk("R10", $sformatf("no pulse without ce cycle %0d", c), int'(ctr_pulse[0]), 0);
    end
    @(negedge clk); pix_ce = 1'b1;
    @(posedge clk); #1;
    chk("R10", "pulse once ce returns", int'(ctr_pulse[0]), 1);
    @(negedge clk); enable = 1'b0;

    summary();
    $finish;
  end
endmodule